// File: doc/BRIEF.md
# Correlated-Noise Byte Substitution Stage

This block is a byte-wide first-round cipher stage. It XORs an input byte with a secret key byte and passes the result through the AES forward S-box. The result is registered. It also hardens the first-order power signature of that step. A second lane, built the same way, receives the same byte in the same cycle. That lane XORs the byte with a separate decoy key and substitutes the result through an identical S-box. Its switching activity therefore follows the data rather than being independent noise. The decoy result is kept internal.

The two key bytes are written as a pair. They may be written only when no data is being presented. A pair whose two bytes are equal is refused, and a sticky error flag is raised. Both lanes sit side by side with one register each, so the protected stage has the same latency and the same logic depth as an unprotected one.

Top module: `nsub_stage`

## Requirements
- R1: One clock edge after a cycle with `din_valid`=1, `dout` equals SBOX(`din` XOR secret key), where SBOX is the AES forward substitution. That is, the multiplicative inverse modulo x^8+x^4+x^3+x+1 (with 0 mapped to 0), followed by the affine map with constant 0x63. For example, SBOX(0x00)=0x63 and SBOX(0x53)=0xED.
- R2: `dout_valid` is 1 in exactly the cycles that follow a cycle with `din_valid`=1, and 0 otherwise.
- R3: After a cycle with `din_valid`=0, `dout` keeps its previous value.
- R4: With `key_load`=1, `din_valid`=0 and `key_sec_in` != `key_dec_in`, both keys are replaced. The new secret key applies to data presented from the next cycle on, and `key_error` returns to 0.
- R5: With `key_load`=1, `din_valid`=0 and `key_sec_in` == `key_dec_in`, both keys keep their old values. `key_error` becomes 1 and stays 1 until a later accepted load.
- R6: `key_load` in a cycle with `din_valid`=1 has no effect: the keys and `key_error` are unchanged.
- R7: The decoy lane computes SBOX(`din` XOR decoy key) on the same edge as the real lane. The decoy key never influences `dout`, and the decoy result never equals `dout` while `dout_valid` is 1.
- R8: A synchronous reset (`rst`=1) clears `dout`, `dout_valid` and `key_error`. It loads the secret key with `RST_SEC` (default 0x00) and the decoy key with `RST_DEC` (default 0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Input data byte |
| din_valid | input | 1 | Data strobe |
| key_load | input | 1 | Key pair write request |
| key_sec_in | input | 8 | New secret key byte |
| key_dec_in | input | 8 | New decoy key byte |
| dout | output | 8 | Registered substituted byte |
| dout_valid | output | 1 | Output valid, one cycle after the strobe |
| key_error | output | 1 | Sticky flag for a refused equal key pair |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- that `dout` holds when no data arrives;
- that the two stored keys are never equal;
- that a key write is refused or ignored in the cases where it must be;
- that both lanes capture on the same edge, with differing results.

The correctness of the substitution values can only be shown by the bench. It sweeps all 256 inputs under several key pairs, including 43/145. The bench also shows that a changed decoy key leaves `dout` untouched, and it checks the reset values.

// File: rtl/nsub_pkg.sv
package nsub_pkg;

   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;

   // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
      end
      return acc;
   endfunction

   function automatic logic [7:0] gf_sq(input logic [7:0] a);
      return gf_mul(a, a);
   endfunction

   // affine output map of the forward substitution
   function automatic logic [7:0] affine(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++)
         r[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ AFFINE_C[i];
      return r;
   endfunction

endpackage

// File: rtl/nsub_sbox.sv
module nsub_sbox #(
   parameter int W     = 8,
   parameter int STYLE = 0   // 0: addition chain for x^254, 1: product of squares
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   import nsub_pkg::*;

   initial begin
      if (W != BYTE_W) $error("nsub_sbox: W must be 8");
      if (STYLE < 0 || STYLE > 1) $error("nsub_sbox: STYLE must be 0 or 1");
   end

   logic [W-1:0] inv;

   generate
      if (STYLE == 0) begin : g_chain
         logic [W-1:0] x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
         always_comb begin
            x2   = gf_sq(a);
            x3   = gf_mul(x2, a);
            x6   = gf_sq(x3);
            x12  = gf_sq(x6);
            x15  = gf_mul(x12, x3);
            x30  = gf_sq(x15);
            x60  = gf_sq(x30);
            x120 = gf_sq(x60);
            x240 = gf_sq(x120);
            x252 = gf_mul(x240, x12);
            inv  = gf_mul(x252, x2);
         end
      end else begin : g_squares
         // 254 = 2+4+8+16+32+64+128
         logic [W-1:0] pw [7];
         logic [W-1:0] prod [7];
         always_comb begin
            pw[0] = gf_sq(a);
            for (int k = 1; k < 7; k++) pw[k] = gf_sq(pw[k-1]);
            prod[0] = pw[0];
            for (int k = 1; k < 7; k++) prod[k] = gf_mul(prod[k-1], pw[k]);
            inv = prod[6];
         end
      end
   endgenerate

   assign y = affine(inv);

endmodule

// File: rtl/nsub_keybank.sv
module nsub_keybank #(
   parameter int              W       = 8,
   parameter logic [W-1:0]    RST_SEC = '0,
   parameter logic [W-1:0]    RST_DEC = '1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic                busy,
   input  logic [W-1:0]        sec_in,
   input  logic [W-1:0]        dec_in,
   output logic [1:0][W-1:0]   keys,     // [0] secret, [1] decoy
   output logic                err
);
   initial begin
      if (RST_SEC == RST_DEC) $error("nsub_keybank: reset keys must differ");
   end

   logic accept, refuse;
   assign accept = load && !busy && (sec_in != dec_in);
   assign refuse = load && !busy && (sec_in == dec_in);

   always_ff @(posedge clk) begin
      if (rst) begin
         keys[0] <= RST_SEC;
         keys[1] <= RST_DEC;
         err     <= 1'b0;
      end else if (accept) begin
         keys[0] <= sec_in;
         keys[1] <= dec_in;
         err     <= 1'b0;
      end else if (refuse) begin
         err     <= 1'b1;
      end
   end

   always @(posedge clk) begin
      if (!rst) AST_KEYS_DISTINCT: assert (keys[0] != keys[1]); // R5
   end

   AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
      busy |=> ($stable(keys) && $stable(err))); // R6

   AST_EQUAL_PAIR_REFUSED: assert property (@(posedge clk) disable iff (rst)
      (load && !busy && sec_in == dec_in) |=> (err && $stable(keys))); // R5

   AST_GOOD_PAIR_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (load && !busy && sec_in != dec_in) |=> (!err && keys[0] == $past(sec_in))); // R4

endmodule

// File: rtl/nsub_lane.sv
module nsub_lane #(
   parameter int W     = 8,
   parameter int STYLE = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] din,
   input  logic [W-1:0] key,
   output logic [W-1:0] q,
   output logic         v
);
   logic [W-1:0] mixed, sub;

   assign mixed = din ^ key;

   nsub_sbox #(.W(W), .STYLE(STYLE)) u_sbox (.a(mixed), .y(sub));

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
         v <= 1'b0;
      end else begin
         v <= en;
         if (en) q <= sub;
      end
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(q)); // R3

endmodule

// File: rtl/nsub_stage.sv
module nsub_stage #(
   parameter int           W         = 8,
   parameter int           SBOX_STYLE = 0,
   parameter logic [W-1:0] RST_SEC   = 8'h00,
   parameter logic [W-1:0] RST_DEC   = 8'hFF
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   input  logic         din_valid,
   input  logic         key_load,
   input  logic [W-1:0] key_sec_in,
   input  logic [W-1:0] key_dec_in,
   output logic [W-1:0] dout,
   output logic         dout_valid,
   output logic         key_error
);
   localparam int LANES = 2;   // lane 0 real, lane 1 decoy

   initial begin
      if (W != 8) $error("nsub_stage: W must be 8");
   end

   logic [1:0][W-1:0]      keys;
   logic [LANES-1:0][W-1:0] lane_q;
   logic [LANES-1:0]        lane_v;

   nsub_keybank #(.W(W), .RST_SEC(RST_SEC), .RST_DEC(RST_DEC)) u_keys (
      .clk(clk), .rst(rst), .load(key_load), .busy(din_valid),
      .sec_in(key_sec_in), .dec_in(key_dec_in),
      .keys(keys), .err(key_error)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         nsub_lane #(.W(W), .STYLE(SBOX_STYLE)) u_lane (
            .clk(clk), .rst(rst), .en(din_valid), .din(din),
            .key(keys[g]), .q(lane_q[g]), .v(lane_v[g])
         );
      end
   endgenerate

   assign dout       = lane_q[0];
   assign dout_valid = lane_v[0];

   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
      din_valid |=> dout_valid); // R2

   AST_NO_VALID_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
      !din_valid |=> !dout_valid); // R2

   AST_LANES_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
      lane_v[0] == lane_v[1]); // R7

   AST_DECOY_DIFFERS: assert property (@(posedge clk) disable iff (rst)
      dout_valid |-> (lane_q[1] != dout)); // R7

endmodule

// File: tb/sim_nsub_stage.sv
module sim_nsub_stage;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] din = '0;
   logic       din_valid = 1'b0;
   logic       key_load = 1'b0;
   logic [7:0] key_sec_in = '0;
   logic [7:0] key_dec_in = '0;
   logic [7:0] dout;
   logic       dout_valid;
   logic       key_error;

   always #4 clk = ~clk;   // 125 MHz

   nsub_stage u0 (
      .clk(clk), .rst(rst), .din(din), .din_valid(din_valid),
      .key_load(key_load), .key_sec_in(key_sec_in), .key_dec_in(key_dec_in),
      .dout(dout), .dout_valid(dout_valid), .key_error(key_error)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int ref_sb [256];

   // behavioural reference state
   int m_sec = 8'h00, m_dec = 8'hFF, m_dout = 0, m_vld = 0, m_err = 0;

   function automatic int gmul(int a, int b);
      int p = 0;
      for (int i = 0; i < 8; i++) begin
         if ((b >> i) & 1) p ^= a;
         a = a << 1;
         if (a & 256) a ^= 9'h11b;
      end
      return p;
   endfunction

   function automatic int rotl(int b, int n);
      return ((b << n) | (b >> (8 - n))) & 255;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_sec = 8'h00; m_dec = 8'hFF; m_dout = 0; m_vld = 0; m_err = 0;
      end else begin
         m_vld = din_valid;
         if (din_valid) m_dout = ref_sb[din ^ m_sec[7:0]];
         else if (key_load) begin
            if (key_sec_in != key_dec_in) begin
               m_sec = key_sec_in; m_dec = key_dec_in; m_err = 0;
            end else m_err = 1;
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst) begin
         check("R1/R3 dout", dout, m_dout);
         check("R2 dout_valid", dout_valid, m_vld);
         check("R5/R4/R6 key_error", key_error, m_err);
      end
   end

   always @(posedge clk) begin
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
         finish_up();
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic load_keys(int s, int d);
      key_load = 1'b1; key_sec_in = s[7:0]; key_dec_in = d[7:0]; din_valid = 1'b0;
      step();
      key_load = 1'b0;
   endtask

   task automatic push(int v);
      din = v[7:0]; din_valid = 1'b1;
      step();
      din_valid = 1'b0;
   endtask

   int saved;

   initial begin
      for (int x = 0; x < 256; x++) begin
         int inv = 0;
         for (int y = 1; y < 256; y++) if (x != 0 && gmul(x, y) == 1) inv = y;
         ref_sb[x] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
      end

      step(); step();
      @(negedge clk);
      check("R8 reset dout", dout, 0);
      check("R8 reset dout_valid", dout_valid, 0);
      check("R8 reset key_error", key_error, 0);
      step();
      rst = 1'b0;

      // R8: reset secret key 0x00, so SBOX(0x00)=0x63
      push(8'h00);
      @(negedge clk); check("R8 reset secret key", dout, 8'h63);
      step();
      push(8'h53);
      @(negedge clk); check("R1 known value", dout, 8'hED);
      step();

      // R1 full sweeps under several pairs, streamed and gapped
      foreach (ref_sb[i]) ;
      for (int p = 0; p < 4; p++) begin
         int ks = (p == 0) ? 43 : (p == 1) ? 145 : (p == 2) ? 8'hFF : 8'h5A;
         int kd = (p == 0) ? 145 : (p == 1) ? 43 : (p == 2) ? 8'h00 : 8'hA5;
         load_keys(ks, kd);
         for (int v = 0; v < 256; v++) begin
            din = v[7:0]; din_valid = 1'b1;
            step();
            if (p[0] && (v % 5 == 0)) begin din_valid = 1'b0; step(); end
         end
         din_valid = 1'b0;
         step();
      end

      // R4 new secret key applies next cycle
      load_keys(43, 145);
      push(8'h10);
      @(negedge clk); check("R4 key applied", dout, ref_sb[8'h10 ^ 43]);
      saved = dout;
      step();

      // R7 decoy key change leaves dout unchanged
      load_keys(43, 7);
      push(8'h10);
      @(negedge clk); check("R7 decoy has no effect", dout, saved);
      step();

      // R5 equal pair refused and sticky
      load_keys(8'h77, 8'h77);
      @(negedge clk); check("R5 error raised", key_error, 1);
      step(); step();
      @(negedge clk); check("R5 error sticky", key_error, 1);
      push(8'h10);
      @(negedge clk); check("R5 old key kept", dout, saved);
      step();

      // R6 load during data ignored
      din = 8'h22; din_valid = 1'b1; key_load = 1'b1;
      key_sec_in = 8'h01; key_dec_in = 8'h02;
      step();
      din_valid = 1'b0; key_load = 1'b0;
      @(negedge clk); check("R6 error unchanged", key_error, 1);
      step();
      push(8'h22);
      @(negedge clk); check("R6 key unchanged", dout, ref_sb[8'h22 ^ 43]);
      step();

      // R4 accepted load clears error
      load_keys(8'h01, 8'h02);
      @(negedge clk); check("R4 error cleared", key_error, 0);
      step();
      push(8'h22);
      @(negedge clk); check("R4 new key used", dout, ref_sb[8'h23]);
      step();

      // R3 hold during idle
      step(); step();
      @(negedge clk); check("R3 hold", dout, ref_sb[8'h23]);
      check("R2 idle valid", dout_valid, 0);

      // R8 reset mid-run
      step();
      rst = 1'b1; step(); rst = 1'b0;
      @(negedge clk);
      check("R8 second reset dout", dout, 0);
      check("R8 second reset error", key_error, 0);
      step();
      push(8'h00);
      @(negedge clk); check("R8 key back to reset", dout, 8'h63);
      step(); step();
      finish_up();
   end

endmodule